// File: doc/BRIEF.md
# Delayed Read Tracker

This block sits on the target side of a bus bridge and follows a single delayed read. A master's read is disconnected so that the bridge can fetch the next cache line. At that point the tracker records the master, the address and the command. It answers retry to the master and to every other agent that shows up while the transaction is outstanding. When the fetch engine signals that prefetched data is ready, the tracker stores the data and starts a discard timer.

When the original master comes back with the same address and command, it gets the data along with a one-cycle hit indication, and the tracker returns to idle. If the timer runs out first, the tracker drops the buffered data, pulses a discard event and goes idle. The next request is then handled as a new one.

A mode bit selects a long or a short discard window. The tracker samples this bit once, when it records the delayed transaction. The block has no bus signalling and no fetch engine of its own. Each response (retry, hit, discard) appears in the cycle after the clock edge that sampled its cause.

Top module: `delayed_read_tracker`

## Requirements
- R1: While reset is held and right after it is released, respRetry, respHit and discardPulse are 0 and respData is 0.
- R2: In idle, a request with reqCmd equal to the read code (default 4'h6) is recorded and answered with respRetry high for one cycle. A request with any other command is ignored: no retry and no hit.
- R3: While a delayed read is outstanding, every request that does not complete it gets respRetry. This covers a request from the recorded master before prefetched data arrives, and a later request that differs in address, command or master.
- R4: Once prefetched data is held, a request with the recorded master, address and command gives respHit high for exactly one cycle, with respData equal to the prefetched data and no retry. The tracker is then idle: the next read is recorded again and answered with retry.
- R5: With the mode bit 0 at capture, discardPulse rises in the 1024th cycle after the edge that sampled prefetch-valid, and not earlier.
- R6: With the mode bit 1 at capture, discardPulse rises in the 128th cycle after the edge that sampled prefetch-valid, and not earlier.
- R7: Changing the mode bit after capture does not alter the discard window of the transaction in progress.
- R8: discardPulse lasts one cycle and the buffered data is dropped. The original master returning afterwards receives retry and no hit.
- R9: Only one delayed read is outstanding at a time. A read from another master while one is pending is retried and not recorded, so the original master still hits later.
- R10: If the matching request is sampled on the same edge at which the timer would expire, the hit is given and no discard occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | AW | Request address |
| reqCmd | input | CW | Request command code |
| reqMaster | input | MW | Identifier of the requesting master |
| pfValid | input | 1 | Prefetched data is valid this cycle |
| pfData | input | DW | Prefetched data |
| timerMode | input | 1 | 1 selects the short discard window |
| respRetry | output | 1 | Request answered with retry |
| respHit | output | 1 | Delayed read completed |
| respData | output | DW | Data returned on a hit, 0 otherwise |
| discardPulse | output | 1 | Buffered data discarded on timeout |

## Verification
The assertions assume three things about the inputs. First, pfValid is raised only while a captured read is waiting for data. Second, each request lasts one cycle. Third, reset is applied before any traffic. Under these assumptions the control and datapath agree on whether a buffer is held, and the timer is zero exactly when a discard is issued. The stimulus keeps to these assumptions. Every prefetch pulse follows a recorded read, and each request is a single-cycle strobe. The timer windows are measured by counting edges from the prefetch pulse, so the boundary cycles of both windows are exercised exactly.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_HOLD = 2'd2
  } drtState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // record master, address, command, mode
    logic loadData;  // store prefetched data and start timer
    logic consume;   // data returned to the original master
    logic dropBuf;   // timer expired, buffer discarded
  } drtStrobe_t;

endpackage

// File: rtl/drt_ctrl.sv
module drt_ctrl
  import drt_pkg::*;
#(
  parameter int CW = 4,
  parameter logic [CW-1:0] READ_CMD = 4'h6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [CW-1:0] reqCmd,
  input  logic       pfValid,
  input  logic       match,
  input  logic       expired,
  input  logic       bufValid,
  output drtStrobe_t st,
  output logic       respRetry,
  output logic       respHit,
  output logic       discardPulse
);

  drtState_t stQ, stN;
  logic retryN, hitN, discN;

  always_comb begin
    stN    = stQ;
    st     = '0;
    retryN = 1'b0;
    hitN   = 1'b0;
    discN  = 1'b0;
    unique case (stQ)
      S_IDLE: begin
        if (reqValid && reqCmd == READ_CMD) begin
          st.capture = 1'b1;
          retryN     = 1'b1;
          stN        = S_WAIT;
        end
      end
      S_WAIT: begin
        retryN = reqValid;
        if (pfValid) begin
          st.loadData = 1'b1;
          stN         = S_HOLD;
        end
      end
      S_HOLD: begin
        if (match) begin
          st.consume = 1'b1;
          hitN       = 1'b1;
          stN        = S_IDLE;
        end else begin
          retryN = reqValid;
          if (expired) begin
            st.dropBuf = 1'b1;
            discN      = 1'b1;
            stN        = S_IDLE;
          end
        end
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ          <= S_IDLE;
      respRetry    <= 1'b0;
      respHit      <= 1'b0;
      discardPulse <= 1'b0;
    end else begin
      stQ          <= stN;
      respRetry    <= retryN;
      respHit      <= hitN;
      discardPulse <= discN;
    end
  end

  // R4: data can only be returned while the datapath holds a buffer
  p_consume_needs_buf_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.capture || !st.consume || bufValid);

  // R9: no new transaction is recorded while a buffer is held
  p_no_capture_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |-> !bufValid);

  // R8: discard event lasts a single cycle
  p_discard_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |=> !discardPulse);

endmodule

// File: rtl/drt_dpath.sv
module drt_dpath
  import drt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int MW = 4,
  parameter int LONG_CYCLES  = 1024,
  parameter int SHORT_CYCLES = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  drtStrobe_t    st,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [CW-1:0] reqCmd,
  input  logic [MW-1:0] reqMaster,
  input  logic [DW-1:0] pfData,
  input  logic          timerMode,
  output logic          match,
  output logic          expired,
  output logic          bufValid,
  output logic [DW-1:0] respData
);

  localparam int TW = $clog2(LONG_CYCLES);
  localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_CYCLES - 1);
  localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_CYCLES - 1);

  logic [AW-1:0] addrQ;
  logic [CW-1:0] cmdQ;
  logic [MW-1:0] masterQ;
  logic [DW-1:0] dataQ;
  logic [TW-1:0] countQ;
  logic          modeQ;

  assign match   = reqValid && reqAddr == addrQ && reqCmd == cmdQ && reqMaster == masterQ;
  assign expired = bufValid && countQ == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      cmdQ     <= '0;
      masterQ  <= '0;
      dataQ    <= '0;
      countQ   <= '0;
      modeQ    <= 1'b0;
      bufValid <= 1'b0;
      respData <= '0;
    end else begin
      if (st.capture) begin
        addrQ   <= reqAddr;
        cmdQ    <= reqCmd;
        masterQ <= reqMaster;
        modeQ   <= timerMode;
      end
      if (st.loadData) begin
        dataQ    <= pfData;
        bufValid <= 1'b1;
        countQ   <= modeQ ? SHORT_LOAD : LONG_LOAD;
      end else if (st.consume || st.dropBuf) begin
        bufValid <= 1'b0;
      end else if (bufValid && countQ != '0) begin
        countQ <= countQ - 1'b1;
      end
      respData <= st.consume ? dataQ : '0;
    end
  end

  // R5: a discard is only ever issued with the timer at zero
  p_drop_on_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.dropBuf |-> countQ == '0);

  // R7: sampled mode cannot change while data is held
  p_mode_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |=> $stable(modeQ));

endmodule

// File: rtl/delayed_read_tracker.sv
module delayed_read_tracker
  import drt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int MW = 4,
  parameter logic [CW-1:0] READ_CMD = 4'h6,
  parameter int LONG_CYCLES  = 1024,
  parameter int SHORT_CYCLES = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [CW-1:0] reqCmd,
  input  logic [MW-1:0] reqMaster,
  input  logic          pfValid,
  input  logic [DW-1:0] pfData,
  input  logic          timerMode,
  output logic          respRetry,
  output logic          respHit,
  output logic [DW-1:0] respData,
  output logic          discardPulse
);

  drtStrobe_t st;
  logic match, expired, bufValid;

  drt_ctrl #(.CW(CW), .READ_CMD(READ_CMD)) u_ctrl (
    .clk, .rstN, .reqValid, .reqCmd, .pfValid,
    .match, .expired, .bufValid, .st,
    .respRetry, .respHit, .discardPulse
  );

  drt_dpath #(
    .AW(AW), .DW(DW), .CW(CW), .MW(MW),
    .LONG_CYCLES(LONG_CYCLES), .SHORT_CYCLES(SHORT_CYCLES)
  ) u_dpath (
    .clk, .rstN, .st, .reqValid, .reqAddr, .reqCmd, .reqMaster,
    .pfData, .timerMode, .match, .expired, .bufValid, .respData
  );

  // R8: the buffer is empty once a discard has been signalled
  p_discard_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> !bufValid);

endmodule

// File: tb/delayed_read_tracker_bench.sv
module delayed_read_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RD = 4'h6;
  localparam logic [3:0] WR = 4'h7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqCmd = '0;
  logic [3:0]  reqMaster = '0;
  logic        pfValid = 1'b0;
  logic [31:0] pfData = '0;
  logic        timerMode = 1'b0;
  logic        respRetry, respHit, discardPulse;
  logic [31:0] respData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic gRetry, gHit, gDisc;
  logic [31:0] gData;

  always #(CLK_PERIOD/2) clk = ~clk;

  delayed_read_tracker u_delayed_read_tracker (
    .clk, .rstN, .reqValid, .reqAddr, .reqCmd, .reqMaster,
    .pfValid, .pfData, .timerMode,
    .respRetry, .respHit, .respData, .discardPulse
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Presents a request for one edge and samples the response after it.
  task automatic sendReq(input logic [31:0] a, input logic [3:0] c, input logic [3:0] m);
    reqValid = 1'b1; reqAddr = a; reqCmd = c; reqMaster = m;
    @(posedge clk); #1;
    gRetry = respRetry; gHit = respHit; gDisc = discardPulse; gData = respData;
    reqValid = 1'b0;
  endtask

  task automatic pfPulse(input logic [31:0] d);
    pfValid = 1'b1; pfData = d;
    @(posedge clk); #1;
    pfValid = 1'b0;
  endtask

  // Counts edges after the prefetch edge until a discard is seen.
  task automatic measureDiscard(input string req, input int limit);
    int seen = 0;
    for (int k = 1; k <= 1100; k++) begin
      @(posedge clk); #1;
      if (discardPulse) begin seen = k; break; end
    end
    check(req, "discard cycle", seen, limit);
    @(posedge clk); #1;
    check("R8", "discard width", discardPulse, 0);
  endtask

  task automatic t_reset;
    #1;
    check("R1", "retry in reset", respRetry, 0);
    check("R1", "hit in reset", respHit, 0);
    check("R1", "discard in reset", discardPulse, 0);
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "retry after reset", respRetry, 0);
    check("R1", "data after reset", respData, 0);
  endtask

  task automatic t_captureAndHit;
    sendReq(32'h100, WR, 4'd1);
    check("R2", "write ignored retry", gRetry, 0);
    check("R2", "write ignored hit", gHit, 0);
    sendReq(32'h100, RD, 4'd1);
    check("R2", "read captured retry", gRetry, 1);
    sendReq(32'h100, RD, 4'd1);
    check("R3", "same master before data retry", gRetry, 1);
    check("R3", "same master before data hit", gHit, 0);
    sendReq(32'h200, RD, 4'd2);
    check("R3", "other agent while waiting", gRetry, 1);
    pfPulse(32'hCAFE0001);
    sendReq(32'h104, RD, 4'd1);
    check("R3", "address mismatch retry", gRetry, 1);
    sendReq(32'h100, 4'hC, 4'd1);
    check("R3", "command mismatch retry", gRetry, 1);
    sendReq(32'h100, RD, 4'd1);
    check("R4", "hit", gHit, 1);
    check("R4", "hit no retry", gRetry, 0);
    check("R4", "hit data", gData, 32'hCAFE0001);
    @(posedge clk); #1;
    check("R4", "hit one cycle", respHit, 0);
    sendReq(32'h300, RD, 4'd3);
    check("R4", "idle after hit, new capture", gRetry, 1);
    pfPulse(32'h3);
    sendReq(32'h300, RD, 4'd3);
    check("R4", "second hit", gHit, 1);
  endtask

  task automatic t_oneOutstanding;
    sendReq(32'h400, RD, 4'd1);
    sendReq(32'h500, RD, 4'd2);
    check("R9", "second master retried", gRetry, 1);
    pfPulse(32'h44);
    sendReq(32'h500, RD, 4'd2);
    check("R9", "second master not recorded", gHit, 0);
    check("R9", "second master retry", gRetry, 1);
    sendReq(32'h400, RD, 4'd1);
    check("R9", "original master hits", gHit, 1);
    check("R9", "original data", gData, 32'h44);
  endtask

  task automatic t_longTimer;
    timerMode = 1'b0;
    sendReq(32'h600, RD, 4'd5);
    pfPulse(32'h66);
    measureDiscard("R5", 1024);
    sendReq(32'h600, RD, 4'd5);
    check("R8", "return after discard no hit", gHit, 0);
    check("R8", "return after discard retry", gRetry, 1);
    pfPulse(32'h67);
    sendReq(32'h600, RD, 4'd5);
    check("R8", "fresh data after discard", gData, 32'h67);
  endtask

  task automatic t_shortTimer;
    timerMode = 1'b1;
    sendReq(32'h700, RD, 4'd6);
    pfPulse(32'h77);
    measureDiscard("R6", 128);
  endtask

  task automatic t_modeSampled;
    timerMode = 1'b0;
    sendReq(32'h800, RD, 4'd7);
    timerMode = 1'b1;
    pfPulse(32'h88);
    measureDiscard("R7", 1024);
    timerMode = 1'b1;
    sendReq(32'h810, RD, 4'd7);
    timerMode = 1'b0;
    pfPulse(32'h89);
    measureDiscard("R7", 128);
  endtask

  task automatic t_hitAtExpiry;
    timerMode = 1'b1;
    sendReq(32'h900, RD, 4'd8);
    pfPulse(32'h99);
    repeat (127) begin @(posedge clk); #1; end
    check("R10", "no discard before boundary", discardPulse, 0);
    sendReq(32'h900, RD, 4'd8);
    check("R10", "hit at expiry edge", gHit, 1);
    check("R10", "no discard at expiry edge", gDisc, 0);
    @(posedge clk); #1;
    check("R10", "no late discard", discardPulse, 0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    t_reset();
    t_captureAndHit();
    t_oneOutstanding();
    t_longTimer();
    t_shortTimer();
    t_modeSampled();
    t_hitAtExpiry();
    finishRun();
  end

endmodule